// File: doc/BRIEF.md
# USB Host Command Register Controller

This block holds the 16-bit command word of a USB host controller and the control logic that acts on it. Software sets the word through a plain write port and reads it back at any time. The block turns the word into control lines for the port signalling engine: run, global suspend, resume signalling, and a request for a low-speed end-of-packet. It also tells the frame scheduler the largest packet it may start during end-of-frame bandwidth reclamation.

Hardware changes some of the bits that software writes:

- In debug single-step mode, it drops run/stop after each completed transaction.
- While the bus is suspended, a wake event (connect, disconnect or K-state) makes it raise force-resume.
- When software clears force-resume, the bit keeps reading 1 until the end-of-packet that ends resume signalling has gone out on the bus.

A halted flag reports when the controller is stopped and idle. The debug bit can be changed only while that flag is set.

Top module: `hc_command_block`

## Requirements
- R1: After reset, the read word is 0000h, halted is 1, runOut, suspendOut, resumeOut, eopReq and loopbackOut are 0, and reclaimBytes is 32.
- R2: Bit 8 (loopback), bit 7 (packet-size select) and bit 6 (configure semaphore) take the written value and read it back. Bits 15:9 and 2:1 always read 0 and ignore writes.
- R3: reclaimBytes is 64 when bit 7 is 1 and 32 when it is 0. loopbackOut follows bit 8.
- R4: When bit 5 (debug) and bit 0 (run) are both 1 and txnDone pulses with no write in that cycle, bit 0 reads 0 from the next cycle. When debug is 0, txnDone leaves bit 0 unchanged.
- R5: halted becomes 1 one cycle after bit 0 reads 0 while txnActive is 0. It holds its value while txnActive is 1. It becomes 0 one cycle after bit 0 reads 1.
- R6: A write while halted is 0 leaves bit 5 unchanged.
- R7: A write with bit 3 (suspend) set is accepted only when bit 0 currently reads 0 and the written bit 0 is also 0. Otherwise bit 3 becomes 0. runOut is 0 whenever suspend is 1.
- R8: While suspend is 1 and bit 4 (force resume) reads 0, a resumeEvt with no write makes bit 4 and resumeOut read 1 from the next cycle. Outside suspend, resumeEvt has no effect.
- R9: Writing bit 4 to 0 while it holds 1 sets eopReq and clears resumeOut from the next cycle. Bit 4 keeps reading 1 until eopDone is seen, and from the cycle after that bit 4 and eopReq read 0. While eopReq is 1, resumeEvt and writes to bit 4 are ignored.
- R10: Software writing bit 4 to 1 drives resumeOut to 1 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the command word |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Current command word as read by software |
| txnDone | input | 1 | One-cycle pulse when a bus transaction completes |
| txnActive | input | 1 | A bus transaction is in progress |
| resumeEvt | input | 1 | Wake event seen on a port |
| eopDone | input | 1 | Resume-ending end-of-packet has finished |
| runOut | output | 1 | Transactions may be scheduled |
| suspendOut | output | 1 | Bus is held in global suspend |
| resumeOut | output | 1 | Drive resume signalling |
| eopReq | output | 1 | Send the low-speed end-of-packet |
| loopbackOut | output | 1 | Port loopback test enable |
| halted | output | 1 | Controller stopped and idle |
| reclaimBytes | output | 7 | Reclamation packet limit in bytes |

## Verification
The hardest state to reach is the window after software clears force-resume but before the end-of-packet has finished. In that window bit 4 still reads 1, eopReq is high, and both wake events and writes must be ignored.

Getting there takes a fixed sequence: stop the controller, enter suspend with run at 0, inject a wake event, and then write bit 4 to 0 while keeping suspend set. The stimulus table walks this sequence and then fires a second wake event inside the window. The debug and halted interplay is reached in a similar way: set debug while halted, start a run, and pulse txnDone with txnActive high.

// File: rtl/hc_cmd_pkg.sv
package hc_cmd_pkg;

  // Bit positions inside the command word (software decodes these)
  localparam int RUN_B  = 0;
  localparam int SUSP_B = 3;
  localparam int FGR_B  = 4;
  localparam int DBG_B  = 5;
  localparam int CFG_B  = 6;
  localparam int MAXP_B = 7;
  localparam int LOOP_B = 8;

  // Strobes from the control unit to the register datapath
  typedef struct packed {
    logic ldRun;     // load run bit with runVal
    logic runVal;
    logic ldDbg;     // load debug bit from write data
    logic ldSusp;    // load suspend bit with suspVal
    logic suspVal;
    logic ldMisc;    // load loopback, packet select and semaphore
    logic setFgr;    // raise force-resume
    logic clrFgr;    // drop force-resume
    logic startEop;  // begin end-of-packet hold
    logic endEop;    // end-of-packet finished
  } cmdStrobe_t;

  // Register state returned to the control unit
  typedef struct packed {
    logic run;
    logic susp;
    logic fgr;
    logic eopPend;
    logic dbg;
    logic cfg;
    logic maxp;
    logic loop;
  } cmdState_t;

endpackage

// File: rtl/hc_cmd_ctrl.sv
module hc_cmd_ctrl
  import hc_cmd_pkg::*;
#(
  parameter int CMD_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CMD_W-1:0] wrData,
  input  logic             txnDone,
  input  logic             txnActive,
  input  logic             resumeEvt,
  input  logic             eopDone,
  input  cmdState_t        state,
  output cmdStrobe_t       strb,
  output logic             halted
);

  logic wrRun, wrSusp, wrFgr;
  logic fgrWritable;
  logic wakeSeen;
  logic stepStop;
  logic unusedWr;

  assign wrRun    = wrData[RUN_B];
  assign wrSusp   = wrData[SUSP_B];
  assign wrFgr    = wrData[FGR_B];
  assign unusedWr = ^{wrData[CMD_W-1:FGR_B+1], wrData[SUSP_B-1:RUN_B+1]};

  // Force-resume is frozen while the closing end-of-packet is pending
  assign fgrWritable = !state.eopPend;

  // Wake event counts only in suspend, before resume has started
  assign wakeSeen = state.susp && resumeEvt && !state.fgr && !state.eopPend && !wrEn;

  // Debug single-step: stop after each finished transaction
  assign stepStop = state.dbg && state.run && txnDone && !wrEn;

  always_comb begin
    strb = '0;
    if (wrEn) begin
      strb.ldRun   = 1'b1;
      strb.runVal  = wrRun;
      strb.ldMisc  = 1'b1;
      strb.ldDbg   = halted;
      strb.ldSusp  = 1'b1;
      strb.suspVal = wrSusp && !state.run && !wrRun;
      if (fgrWritable) begin
        if (wrFgr && !state.fgr) begin
          strb.setFgr = 1'b1;
        end else if (!wrFgr && state.fgr) begin
          strb.clrFgr   = 1'b1;
          strb.startEop = 1'b1;
        end
      end
    end else if (stepStop) begin
      strb.ldRun  = 1'b1;
      strb.runVal = 1'b0;
    end
    if (wakeSeen) begin
      strb.setFgr = 1'b1;
    end
    strb.endEop = state.eopPend && eopDone;
  end

  // Halted tracks the registered run bit with one cycle of lag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      halted <= 1'b1;
    end else if (state.run) begin
      halted <= 1'b0;
    end else if (!txnActive) begin
      halted <= 1'b1;
    end
  end

endmodule

// File: rtl/hc_cmd_datapath.sv
module hc_cmd_datapath
  import hc_cmd_pkg::*;
#(
  parameter int CMD_W     = 16,
  parameter int SMALL_PKT = 32,
  parameter int LARGE_PKT = 64,
  parameter int BYTE_W    = $clog2(LARGE_PKT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CMD_W-1:0]  wrData,
  input  cmdStrobe_t        strb,
  output cmdState_t         state,
  output logic [CMD_W-1:0]  rdData,
  output logic              runOut,
  output logic              suspendOut,
  output logic              resumeOut,
  output logic              eopReq,
  output logic              loopbackOut,
  output logic [BYTE_W-1:0] reclaimBytes
);

  localparam logic [BYTE_W-1:0] SMALL_V = BYTE_W'(SMALL_PKT);
  localparam logic [BYTE_W-1:0] LARGE_V = BYTE_W'(LARGE_PKT);

  cmdState_t cur;
  logic      unusedWr;

  assign unusedWr = ^{wrData[CMD_W-1:LOOP_B+1], wrData[FGR_B:RUN_B]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur <= '0;
    end else begin
      if (strb.ldRun)  cur.run  <= strb.runVal;
      if (strb.ldSusp) cur.susp <= strb.suspVal;
      if (strb.ldDbg)  cur.dbg  <= wrData[DBG_B];
      if (strb.ldMisc) begin
        cur.cfg  <= wrData[CFG_B];
        cur.maxp <= wrData[MAXP_B];
        cur.loop <= wrData[LOOP_B];
      end
      if (strb.setFgr)      cur.fgr <= 1'b1;
      else if (strb.clrFgr) cur.fgr <= 1'b0;
      if (strb.startEop)    cur.eopPend <= 1'b1;
      else if (strb.endEop) cur.eopPend <= 1'b0;
    end
  end

  assign state = cur;

  // Readback: reserved positions stay zero
  always_comb begin
    rdData         = '0;
    rdData[RUN_B]  = cur.run;
    rdData[SUSP_B] = cur.susp;
    rdData[FGR_B]  = cur.fgr || cur.eopPend;
    rdData[DBG_B]  = cur.dbg;
    rdData[CFG_B]  = cur.cfg;
    rdData[MAXP_B] = cur.maxp;
    rdData[LOOP_B] = cur.loop;
  end

  assign runOut       = cur.run && !cur.susp;
  assign suspendOut   = cur.susp;
  assign resumeOut    = cur.fgr && !cur.eopPend;
  assign eopReq       = cur.eopPend;
  assign loopbackOut  = cur.loop;
  assign reclaimBytes = cur.maxp ? LARGE_V : SMALL_V;

endmodule

// File: rtl/hc_command_block.sv
module hc_command_block
  import hc_cmd_pkg::*;
#(
  parameter int CMD_W     = 16,
  parameter int SMALL_PKT = 32,
  parameter int LARGE_PKT = 64,
  parameter int BYTE_W    = $clog2(LARGE_PKT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CMD_W-1:0]  wrData,
  output logic [CMD_W-1:0]  rdData,
  input  logic              txnDone,
  input  logic              txnActive,
  input  logic              resumeEvt,
  input  logic              eopDone,
  output logic              runOut,
  output logic              suspendOut,
  output logic              resumeOut,
  output logic              eopReq,
  output logic              loopbackOut,
  output logic              halted,
  output logic [BYTE_W-1:0] reclaimBytes
);

  cmdStrobe_t strb;
  cmdState_t  state;

  hc_cmd_ctrl #(.CMD_W(CMD_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .txnDone   (txnDone),
    .txnActive (txnActive),
    .resumeEvt (resumeEvt),
    .eopDone   (eopDone),
    .state     (state),
    .strb      (strb),
    .halted    (halted)
  );

  hc_cmd_datapath #(
    .CMD_W     (CMD_W),
    .SMALL_PKT (SMALL_PKT),
    .LARGE_PKT (LARGE_PKT),
    .BYTE_W    (BYTE_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .wrData       (wrData),
    .strb         (strb),
    .state        (state),
    .rdData       (rdData),
    .runOut       (runOut),
    .suspendOut   (suspendOut),
    .resumeOut    (resumeOut),
    .eopReq       (eopReq),
    .loopbackOut  (loopbackOut),
    .reclaimBytes (reclaimBytes)
  );

endmodule

// File: rtl/hc_command_chk.sv
module hc_command_chk #(
  parameter int CMD_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [CMD_W-1:0] wrData,
  input logic             txnDone,
  input logic             resumeEvt,
  input logic [CMD_W-1:0] rdData,
  input logic             halted,
  input logic             runOut,
  input logic             suspendOut,
  input logic             resumeOut,
  input logic             eopReq
);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[CMD_W-1:9] == '0) && (rdData[2:1] == 2'b00));

  // R4
  dbg_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[5] && rdData[0] && txnDone && !wrEn) |=> !rdData[0]);

  // R5
  halt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[0] |=> !halted);

  // R6
  dbg_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !halted) |=> $stable(rdData[5]));

  // R7
  susp_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[3] && (rdData[0] || wrData[0])) |=> !suspendOut);

  // R7
  no_run_in_susp_chk: assert property (@(posedge clk) disable iff (!rstN)
    suspendOut |-> !runOut);

  // R8
  wake_resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (suspendOut && resumeEvt && !rdData[4] && !wrEn) |=> resumeOut);

  // R9
  eop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    eopReq |-> (rdData[4] && !resumeOut));

endmodule

bind hc_command_block hc_command_chk #(.CMD_W(CMD_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .txnDone    (txnDone),
  .resumeEvt  (resumeEvt),
  .rdData     (rdData),
  .halted     (halted),
  .runOut     (runOut),
  .suspendOut (suspendOut),
  .resumeOut  (resumeOut),
  .eopReq     (eopReq)
);

// File: tb/hc_command_block_bench.sv
`timescale 1ns/1ps
module hc_command_block_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        txnDone = 1'b0, txnActive = 1'b0, resumeEvt = 1'b0, eopDone = 1'b0;
  logic        runOut, suspendOut, resumeOut, eopReq, loopbackOut, halted;
  logic [6:0]  reclaimBytes;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hc_command_block u_hc_command_block (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .txnDone(txnDone), .txnActive(txnActive), .resumeEvt(resumeEvt), .eopDone(eopDone),
    .runOut(runOut), .suspendOut(suspendOut), .resumeOut(resumeOut), .eopReq(eopReq),
    .loopbackOut(loopbackOut), .halted(halted), .reclaimBytes(reclaimBytes)
  );

  // Vector: {wr, data, {txnDone,resumeEvt,eopDone,txnActive}, expRd,
  //          {halted,runOut,suspendOut,resumeOut,eopReq}}
  localparam int NV = 26;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 16'h0000, 4'b0000, 16'h0000, 5'b10000}, //  0 R1 idle
    {1'b1, 16'h01C0, 4'b0000, 16'h01C0, 5'b10000}, //  1 R2 misc bits
    {1'b1, 16'h0021, 4'b0000, 16'h0021, 5'b11000}, //  2 R6 debug set while halted
    {1'b0, 16'h0000, 4'b0001, 16'h0021, 5'b01000}, //  3 R5 halted drops
    {1'b0, 16'h0000, 4'b1001, 16'h0020, 5'b00000}, //  4 R4 step stop
    {1'b0, 16'h0000, 4'b0000, 16'h0020, 5'b10000}, //  5 R5 halted rises
    {1'b1, 16'h0001, 4'b0000, 16'h0001, 5'b11000}, //  6 R6 debug cleared
    {1'b1, 16'h0000, 4'b0000, 16'h0000, 5'b00000}, //  7 R5
    {1'b1, 16'h0020, 4'b0001, 16'h0000, 5'b00000}, //  8 R6 debug write ignored
    {1'b0, 16'h0000, 4'b0000, 16'h0000, 5'b10000}, //  9 R5
    {1'b1, 16'h0009, 4'b0000, 16'h0001, 5'b11000}, // 10 R7 suspend with run written
    {1'b1, 16'h0008, 4'b0000, 16'h0000, 5'b00000}, // 11 R7 suspend while running
    {1'b1, 16'h0008, 4'b0000, 16'h0008, 5'b10100}, // 12 R7 suspend accepted
    {1'b0, 16'h0000, 4'b0100, 16'h0018, 5'b10110}, // 13 R8 wake
    {1'b1, 16'h0008, 4'b0000, 16'h0018, 5'b10101}, // 14 R9 clear resume
    {1'b0, 16'h0000, 4'b0100, 16'h0018, 5'b10101}, // 15 R9 wake during EOP
    {1'b0, 16'h0000, 4'b0010, 16'h0008, 5'b10100}, // 16 R9 EOP done
    {1'b1, 16'h0000, 4'b0000, 16'h0000, 5'b10000}, // 17 R7 leave suspend
    {1'b0, 16'h0000, 4'b0100, 16'h0000, 5'b10000}, // 18 R8 wake ignored
    {1'b1, 16'h0010, 4'b0000, 16'h0010, 5'b10010}, // 19 R10 software resume
    {1'b1, 16'h0000, 4'b0000, 16'h0010, 5'b10001}, // 20 R9
    {1'b0, 16'h0000, 4'b0010, 16'h0000, 5'b10000}, // 21 R9
    {1'b1, 16'h0081, 4'b0000, 16'h0081, 5'b11000}, // 22 R2
    {1'b0, 16'h0000, 4'b1000, 16'h0081, 5'b01000}, // 23 R4 no debug, run kept
    {1'b1, 16'h0089, 4'b0000, 16'h0081, 5'b01000}, // 24 R7
    {1'b1, 16'hFE06, 4'b0000, 16'h0000, 5'b00000}  // 25 R2 reserved bits
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [15:0] d, input logic [3:0] ctl);
    @(negedge clk);
    wrEn = wr; wrData = d;
    {txnDone, resumeEvt, eopDone, txnActive} = ctl;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 rdData", rdData, 16'h0000);
    check("R1 flags", {11'd0, halted, runOut, suspendOut, resumeOut, eopReq},
          {11'd0, 5'b10000});
    check("R1 reclaim", {9'd0, reclaimBytes}, 16'd32);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][41], VEC[i][40:25], VEC[i][24:21]);
      check($sformatf("vector %0d rdData", i), rdData, VEC[i][20:5]);
      check($sformatf("vector %0d flags", i),
            {11'd0, halted, runOut, suspendOut, resumeOut, eopReq}, {11'd0, VEC[i][4:0]});
    end

    // R3 packet select and loopback
    step(1'b1, 16'h0180, 4'b0000);
    check("R3 reclaim 64", {9'd0, reclaimBytes}, 16'd64);
    check("R3 loopback on", {15'd0, loopbackOut}, 16'd1);
    step(1'b1, 16'h0000, 4'b0000);
    check("R3 reclaim 32", {9'd0, reclaimBytes}, 16'd32);
    check("R3 loopback off", {15'd0, loopbackOut}, 16'd0);

    // R9 write to resume bit during EOP hold is ignored
    step(1'b1, 16'h0010, 4'b0000);
    step(1'b1, 16'h0000, 4'b0000);
    step(1'b1, 16'h0010, 4'b0000);
    check("R9 write during EOP", {14'd0, resumeOut, eopReq}, 16'b01);
    step(1'b0, 16'h0000, 4'b0010);
    check("R9 EOP end", rdData, 16'h0000);

    // R1 reset from a busy state
    step(1'b1, 16'h01A1, 4'b0000);
    @(negedge clk) rstN = 1'b0; wrEn = 1'b0;
    @(posedge clk); #1;
    check("R1 mid reset rdData", rdData, 16'h0000);
    check("R1 mid reset flags",
          {10'd0, loopbackOut, halted, runOut, suspendOut, resumeOut, eopReq},
          {10'd0, 6'b010000});
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    finish_run();
  end

endmodule